// File: doc/BRIEF.md
# Logic Probe Indicator Controller

This block sits between the comparator front end of a digital logic probe and its two lamps. The front end delivers two flags: one set while the probed node sits above the upper threshold, one set while it sits below the lower threshold. The block synchronizes the flags, classifies the node as low, high or undefined, and drives the main lamp: dark for low, lit for high, and a dim pulse-width-modulated glow for a floating node or a bad level.

Any clean swing between low and high is treated as pulse activity. It makes the lamp show the opposite of the static level for a stretch window, so a very short pulse still gives a visible blink. A fast pulse train is paced so that blinks start no more often than once per lamp period. A second lamp latches the first swing after the user presses the clear button and holds until the next press. A family-select bit is passed through to the front end to choose its threshold set.

Top module: `probe_lamp_top`

## Requirements
- R1: With aboveHigh=0 and belowLow=1 (valid low) held steady and no flash running, lampOut is constantly 0.
- R2: With aboveHigh=1 and belowLow=0 (valid high) held steady and no flash running, lampOut is constantly 1.
- R3: With both flags equal (00 floating, 11 bad level), lampOut is a PWM with a duty of 1/8: it is high for 2**PWM_BITS/8 cycles out of every 2**PWM_BITS cycles.
- R4: A direct change between valid low and valid high starts a flash when none is running. During the flash, which lasts STRETCH_CYC cycles, lampOut shows the inverse of the static level (low gives 1, high gives 0, undefined gives 1). After the flash the static display returns.
- R5: Flash starts are at least PERIOD_CYC cycles apart. Swings seen in the part of a period that follows the flash start one further flash at the end of that period, so a continuous train blinks once per period.
- R6: A change into or out of the undefined state is not pulse activity. It starts no flash and does not set memLamp.
- R7: memClr=1 at a clock edge turns memLamp off. The next valid low/high swing turns memLamp on, and it stays on until the next clear. Clear wins over a swing in the same cycle.
- R8: famSelOut follows famSelIn one clock cycle later (0 selects the TTL threshold set, 1 selects the CMOS set).
- R9: While rst is high, lampOut, memLamp and famSelOut are all 0 after each clock edge.
- R10: An isolated pulse whose two swings both fall inside one flash produces exactly one flash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| aboveHigh | input | 1 | Front-end flag: node above the upper threshold |
| belowLow | input | 1 | Front-end flag: node below the lower threshold |
| famSelIn | input | 1 | Logic-family choice (0 TTL, 1 CMOS) |
| memClr | input | 1 | Memory clear button, already debounced |
| lampOut | output | 1 | Main indicator lamp drive |
| memLamp | output | 1 | Pulse-memory lamp drive |
| famSelOut | output | 1 | Threshold-set select sent to the front end |

## Verification
The assertions assume that the level flags, once past the two-flop synchronizer, are stable enough that the classified level changes at most once per clock. They also assume that memClr is a clean synchronous pulse. The stimulus changes flags only at falling clock edges and holds every level for whole cycles. The shortest glitch it drives lasts one full cycle, so every swing reaches the classifier intact. The pacing and stretch limits are checked on shortened counter parameters, and the train used by the stimulus packs many swings into each lamp period.

// File: rtl/probe_pkg.sv
package probe_pkg;
  typedef enum logic [1:0] {
    LVL_LOW   = 2'b00,
    LVL_HIGH  = 2'b01,
    LVL_UNDEF = 2'b10
  } level_t;

  typedef struct packed {
    logic flashOn;
  } ctlStrobes_t;
endpackage

// File: rtl/probe_datapath.sv
module probe_datapath
  import probe_pkg::*;
#(
  parameter int PWM_BITS = 14
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        aboveHigh,
  input  logic        belowLow,
  input  logic        famSelIn,
  input  logic        memClr,
  input  ctlStrobes_t strobes,
  output logic        pulseEvt,
  output logic        lampOut,
  output logic        memLamp,
  output logic        famSelOut
);
  localparam int PWM_PERIOD = 2 ** PWM_BITS;
  localparam logic [PWM_BITS-1:0] DIM_ON = PWM_BITS'(PWM_PERIOD / 8);

  logic [1:0] syncA, syncB;
  level_t curLvl, prevLvl;
  logic [PWM_BITS-1:0] pwmCnt;
  logic lampQ, memQ, famQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {aboveHigh, belowLow};
      syncB <= syncA;
    end
  end

  always_comb begin
    unique case (syncB)
      2'b10:   curLvl = LVL_HIGH;
      2'b01:   curLvl = LVL_LOW;
      default: curLvl = LVL_UNDEF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prevLvl <= LVL_UNDEF;
    else     prevLvl <= curLvl;
  end

  assign pulseEvt = (curLvl != LVL_UNDEF) && (prevLvl != LVL_UNDEF) && (curLvl != prevLvl);

  always_ff @(posedge clk) begin
    if (rst) pwmCnt <= '0;
    else     pwmCnt <= pwmCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lampQ <= 1'b0;
    end else if (strobes.flashOn) begin
      lampQ <= (curLvl != LVL_HIGH);
    end else begin
      unique case (curLvl)
        LVL_HIGH: lampQ <= 1'b1;
        LVL_LOW:  lampQ <= 1'b0;
        default:  lampQ <= (pwmCnt < DIM_ON);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || memClr) memQ <= 1'b0;
    else if (pulseEvt) memQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) famQ <= 1'b0;
    else     famQ <= famSelIn;
  end

  assign lampOut   = lampQ;
  assign memLamp   = memQ;
  assign famSelOut = famQ;

  // R2
  high_lit_chk: assert property (@(posedge clk) disable iff (rst)
    (curLvl == LVL_HIGH && !strobes.flashOn) |=> lampOut);
  // R6
  mem_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(memLamp) |-> ($past(curLvl) != LVL_UNDEF && $past(prevLvl) != LVL_UNDEF));
  // R7
  mem_clear_chk: assert property (@(posedge clk) disable iff (rst)
    memClr |=> !memLamp);
  // R9
  reset_dark_chk: assert property (@(posedge clk)
    rst |=> (!lampOut && !memLamp && !famSelOut));
endmodule

// File: rtl/probe_control.sv
module probe_control
  import probe_pkg::*;
#(
  parameter int STRETCH_CYC = 2_500_000,
  parameter int PERIOD_CYC  = 5_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pulseEvt,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = $clog2(PERIOD_CYC + 1);
  localparam logic [CNT_W-1:0] STRETCH_LAST = CNT_W'(STRETCH_CYC - 1);
  localparam logic [CNT_W-1:0] PERIOD_LAST  = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] PERIOD_FULL  = CNT_W'(PERIOD_CYC);
  localparam logic [CNT_W-1:0] STRETCH_LIM  = CNT_W'(STRETCH_CYC);

  typedef enum logic [1:0] {PH_IDLE, PH_FLASH, PH_HOLD} phase_t;

  phase_t phase;
  logic [CNT_W-1:0] cnt;
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (pulseEvt) begin
            phase   <= PH_FLASH;
            cnt     <= '0;
            pending <= 1'b0;
          end
        end
        PH_FLASH: begin
          cnt <= cnt + 1'b1;
          if (cnt == STRETCH_LAST) phase <= PH_HOLD;
        end
        default: begin
          if (cnt == PERIOD_LAST) begin
            cnt     <= '0;
            pending <= 1'b0;
            phase   <= (pending || pulseEvt) ? PH_FLASH : PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            if (pulseEvt) pending <= 1'b1;
          end
        end
      endcase
    end
  end

  assign strobes.flashOn = (phase == PH_FLASH);

  logic flashPrev;
  logic [CNT_W-1:0] gapCnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      flashPrev <= 1'b0;
      gapCnt    <= PERIOD_FULL;
    end else begin
      flashPrev <= strobes.flashOn;
      if (strobes.flashOn && !flashPrev) gapCnt <= CNT_W'(1);
      else if (gapCnt < PERIOD_FULL)     gapCnt <= gapCnt + 1'b1;
    end
  end

  // R5
  flash_pace_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.flashOn && !flashPrev) |-> gapCnt >= PERIOD_FULL);
  // R4
  stretch_bound_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.flashOn |-> cnt < STRETCH_LIM);
endmodule

// File: rtl/probe_lamp_top.sv
module probe_lamp_top
  import probe_pkg::*;
#(
  parameter int STRETCH_CYC = 2_500_000,
  parameter int PERIOD_CYC  = 5_000_000,
  parameter int PWM_BITS    = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic aboveHigh,
  input  logic belowLow,
  input  logic famSelIn,
  input  logic memClr,
  output logic lampOut,
  output logic memLamp,
  output logic famSelOut
);
  ctlStrobes_t strobes;
  logic pulseEvt;

  probe_datapath #(.PWM_BITS(PWM_BITS)) u_dp (
    .clk(clk), .rst(rst), .aboveHigh(aboveHigh), .belowLow(belowLow),
    .famSelIn(famSelIn), .memClr(memClr), .strobes(strobes),
    .pulseEvt(pulseEvt), .lampOut(lampOut), .memLamp(memLamp),
    .famSelOut(famSelOut)
  );

  probe_control #(.STRETCH_CYC(STRETCH_CYC), .PERIOD_CYC(PERIOD_CYC)) u_ctl (
    .clk(clk), .rst(rst), .pulseEvt(pulseEvt), .strobes(strobes)
  );
endmodule

// File: tb/sim_probe_lamp_top.sv
module sim_probe_lamp_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aboveHigh = 1'b0, belowLow = 1'b0, famSelIn = 1'b0, memClr = 1'b0;
  logic lampOut, memLamp, famSelOut;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  probe_lamp_top #(.STRETCH_CYC(40), .PERIOD_CYC(80), .PWM_BITS(4)) u0 (
    .clk(clk), .rst(rst), .aboveHigh(aboveHigh), .belowLow(belowLow),
    .famSelIn(famSelIn), .memClr(memClr), .lampOut(lampOut),
    .memLamp(memLamp), .famSelOut(famSelOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setIn(input logic hi, input logic lo);
    @(negedge clk);
    aboveHigh = hi;
    belowLow  = lo;
  endtask

  task automatic pulseClr();
    @(negedge clk);
    memClr = 1'b1;
    @(negedge clk);
    memClr = 1'b0;
  endtask

  task automatic countOn(input int n, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (lampOut) ones++;
    end
  endtask

  task automatic testReset();
    waitCyc(3);
    check(lampOut == 0, "R9 lamp", int'(lampOut), 0);
    check(memLamp == 0, "R9 mem", int'(memLamp), 0);
    check(famSelOut == 0, "R9 fam", int'(famSelOut), 0);
    rst = 1'b0;
  endtask

  task automatic testLow();
    int ones;
    setIn(1'b0, 1'b1);
    waitCyc(120);
    countOn(20, ones);
    check(ones == 0, "R1 low dark", ones, 0);
  endtask

  task automatic testHigh();
    int ones;
    setIn(1'b1, 1'b0);
    waitCyc(120);
    countOn(20, ones);
    check(ones == 20, "R2 high lit", ones, 20);
  endtask

  task automatic testStep();
    setIn(1'b0, 1'b1);
    waitCyc(10);
    check(lampOut == 1, "R4 inverse early", int'(lampOut), 1);
    waitCyc(25);
    check(lampOut == 1, "R4 inverse late", int'(lampOut), 1);
    waitCyc(25);
    check(lampOut == 0, "R4 static back", int'(lampOut), 0);
    waitCyc(90);
  endtask

  task automatic testShort();
    int ones;
    setIn(1'b1, 1'b0);
    setIn(1'b0, 1'b1);
    waitCyc(10);
    check(lampOut == 1, "R10 flash on", int'(lampOut), 1);
    waitCyc(50);
    check(lampOut == 0, "R10 flash over", int'(lampOut), 0);
    countOn(100, ones);
    check(ones == 0, "R10 single flash", ones, 0);
  endtask

  task automatic testUndef();
    int ones;
    setIn(1'b0, 1'b0);
    waitCyc(120);
    countOn(64, ones);
    check(ones == 8, "R3 floating duty", ones, 8);
    setIn(1'b1, 1'b1);
    waitCyc(20);
    countOn(64, ones);
    check(ones == 8, "R3 bad level duty", ones, 8);
  endtask

  task automatic testNoPulse();
    pulseClr();
    setIn(1'b0, 1'b1);
    waitCyc(10);
    check(lampOut == 0, "R6 undef to low no flash", int'(lampOut), 0);
    setIn(1'b0, 1'b0);
    waitCyc(10);
    setIn(1'b1, 1'b0);
    waitCyc(10);
    check(lampOut == 1, "R6 undef to high no flash", int'(lampOut), 1);
    check(memLamp == 0, "R6 mem untouched", int'(memLamp), 0);
    waitCyc(100);
  endtask

  task automatic testMem();
    pulseClr();
    waitCyc(3);
    check(memLamp == 0, "R7 cleared", int'(memLamp), 0);
    setIn(1'b0, 1'b1);
    waitCyc(5);
    check(memLamp == 1, "R7 set", int'(memLamp), 1);
    waitCyc(200);
    check(memLamp == 1, "R7 held", int'(memLamp), 1);
    pulseClr();
    waitCyc(2);
    check(memLamp == 0, "R7 clear again", int'(memLamp), 0);
  endtask

  task automatic testTrain();
    int offCnt = 0;
    setIn(1'b1, 1'b0);
    waitCyc(150);
    for (int p = 0; p < 40; p++) begin
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        aboveHigh = (c != 0);
        belowLow  = (c == 0);
        if (!lampOut) offCnt++;
      end
    end
    check(offCnt >= 150 && offCnt <= 260, "R5 paced blinking", offCnt, 200);
    @(negedge clk);
    aboveHigh = 1'b1;
    belowLow  = 1'b0;
    waitCyc(200);
  endtask

  task automatic testFam();
    @(negedge clk);
    famSelIn = 1'b1;
    @(negedge clk);
    check(famSelOut == 1, "R8 cmos select", int'(famSelOut), 1);
    famSelIn = 1'b0;
    @(negedge clk);
    check(famSelOut == 0, "R8 ttl select", int'(famSelOut), 0);
  endtask

  initial begin
    testReset();
    testLow();
    testHigh();
    testStep();
    testShort();
    testUndef();
    testNoPulse();
    testMem();
    testTrain();
    testFam();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule